// File: doc/BRIEF.md
# Bus Target Cycle Decoder

This block is the target (slave) side of a 32-bit bus that carries addresses and data on the same lines and samples everything on the rising edge of one clock. It watches the cycle-frame input for the start of a transaction and takes the first clock of each transaction as the address phase. In that clock it captures the address and the four-bit command, then decides whether this device should answer.

Memory read and memory write commands are claimed when the address falls inside a 256-byte window at a base address set by parameter. Configuration read and configuration write commands are claimed only when the configuration-select input is high, whatever the address. Any other command is left alone. Decoding is suppressed while the device is acting as bus master. A claimed cycle pulls device-select and target-ready low for a single data phase.

In the data phase the block hands the cycle to an internal register port. On reads it drives the register value onto the bus. On writes it merges the enabled byte lanes into a write register and raises a one-cycle write strobe.

Top module: `tgt_cycle_decoder`

## Requirements
- R1: After reset, devsel_n and trdy_n are 1, and ad_oe, reg_wr_en, reg_wdata and reg_wbe are 0.
- R2: A memory read (cbe_n 4'b0110) or memory write (4'b0111) address phase whose address bits [31:8] equal those of BASE_ADDR drives devsel_n low in the cycle after the address-phase edge.
- R3: An address phase is not claimed, and devsel_n stays 1, when a memory command's address lies outside the window, or when the command is anything other than 0110, 0111, 1010 or 1011 (for example 0010).
- R4: Configuration read (4'b1010) and configuration write (4'b1011) are claimed at any address when idsel is 1 at the address phase, and are not claimed when idsel is 0. idsel has no effect on memory commands.
- R5: When master_busy is 1 at the address phase, no command is claimed.
- R6: An address phase is a rising edge at which frame_n is 0 after it was 1 at the previous rising edge. While frame_n is held low, no new address phase is seen.
- R7: During a claimed data phase, reg_addr holds address bits [7:2] and reg_cfg is 1 exactly for configuration commands. On reads, ad_oe is 1 and ad_out equals reg_rdata. On writes, ad_oe is 0.
- R8: A claimed write completes at the first data-phase edge with irdy_n 0. In the next cycle reg_wr_en is 1 for exactly one cycle. Each byte lane i of reg_wdata (bits 8i+7:8i, lane 0 = bits 7:0) takes ad_in's lane only if cbe_n[i] is 0 and otherwise keeps its previous value. reg_wbe equals ~cbe_n.
- R9: While irdy_n is 1 in the data phase, devsel_n and trdy_n stay low. They return to 1 in the cycle after the completing edge.
- R10: trdy_n equals devsel_n in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration chip select, active high |
| master_busy | input | 1 | High while this device owns the bus as master |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| ad_in | input | 32 | Address/data lines as seen on the bus |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Output enable for ad_out |
| devsel_n | output | 1 | Device select (claim), active low |
| trdy_n | output | 1 | Target ready, active low |
| reg_addr | output | 6 | Double-word index inside the window |
| reg_cfg | output | 1 | Current cycle is a configuration cycle |
| reg_rdata | input | 32 | Read value from the register file |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 32 | Lane-merged write data |
| reg_wbe | output | 4 | Active-high byte enables of the last write |

## Verification
The corner cases the bench aims at are the two window edges (0x...100, 0x...1FC, and one double word on either side), idsel on memory commands, and master_busy at an address phase. A decoder that compared too few address bits, or let idsel select memory cycles, would claim a cycle that belongs to another device. A partial-lane write followed by another write checks that disabled lanes keep their old bytes; a design that cleared or overwrote them would corrupt neighbouring register bytes. Wait states and a frame held low across completion check that the claim is neither dropped early nor started again from a stale frame level.

// File: rtl/tgt_dec_pkg.sv
package tgt_dec_pkg;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic {ST_IDLE = 1'b0, ST_DATA = 1'b1} tgt_state_e;

  function automatic logic cmd_is_mem(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  endfunction

  function automatic logic cmd_is_cfg(input logic [3:0] cmd);
    return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  endfunction

  // Bit 0 of all four claimed commands marks the write direction.
  function automatic logic cmd_is_write(input logic [3:0] cmd);
    return cmd[0];
  endfunction

  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input int unsigned win_bits);
    return (addr >> win_bits) == (base >> win_bits);
  endfunction

  function automatic logic [7:0] lane_pick(input logic [7:0] old_b,
                                           input logic [7:0] new_b,
                                           input logic en_n);
    return en_n ? old_b : new_b;
  endfunction

endpackage

// File: rtl/tgt_addr_decode.sv
module tgt_addr_decode
  import tgt_dec_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0100,
  parameter int unsigned WIN_BITS  = 8
) (
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  input  logic        idsel,
  input  logic        master_busy,
  output logic        win_hit,
  output logic        is_cfg,
  output logic        is_write,
  output logic        claim_ok
);

  logic mem_cmd;

  always_comb begin
    mem_cmd  = cmd_is_mem(cbe_n);
    is_cfg   = cmd_is_cfg(cbe_n);
    is_write = cmd_is_write(cbe_n);
    win_hit  = in_window(ad_in, BASE_ADDR, WIN_BITS);
    claim_ok = !master_busy && ((mem_cmd && win_hit) || (is_cfg && idsel));
  end

endmodule

// File: rtl/tgt_phase_fsm.sv
module tgt_phase_fsm
  import tgt_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic claim_ok,
  output logic addr_ph,
  output logic accept,
  output logic in_data,
  output logic done,
  output logic devsel_n,
  output logic trdy_n
);

  tgt_state_e st_q;
  logic       frame_q;

  always_comb begin
    addr_ph  = !frame_n && frame_q && (st_q == ST_IDLE);
    accept   = addr_ph && claim_ok;
    in_data  = (st_q == ST_DATA);
    done     = in_data && !irdy_n;
    devsel_n = !in_data;
    trdy_n   = !in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      frame_q <= 1'b1;
    end else begin
      frame_q <= frame_n;
      case (st_q)
        ST_IDLE: if (accept) st_q <= ST_DATA;
        ST_DATA: if (!irdy_n) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tgt_wr_capture.sv
module tgt_wr_capture
  import tgt_dec_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned DW   = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DW-1:0]    ad_in,
  input  logic [LANES-1:0] cbe_n,
  output logic [DW-1:0]    wdata,
  output logic [LANES-1:0] wbe,
  output logic             wr_en
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wdata[g*8 +: 8] <= '0;
      end else if (load) begin
        wdata[g*8 +: 8] <= lane_pick(wdata[g*8 +: 8], ad_in[g*8 +: 8], cbe_n[g]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbe   <= '0;
      wr_en <= 1'b0;
    end else begin
      wr_en <= load;
      if (load) wbe <= ~cbe_n;
    end
  end

endmodule

// File: rtl/tgt_cycle_decoder.sv
module tgt_cycle_decoder
  import tgt_dec_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0100,
  parameter int unsigned WIN_BITS  = 8,
  localparam int unsigned REG_AW   = WIN_BITS - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              idsel,
  input  logic              master_busy,
  input  logic [3:0]        cbe_n,
  input  logic [31:0]       ad_in,
  output logic [31:0]       ad_out,
  output logic              ad_oe,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_cfg,
  input  logic [31:0]       reg_rdata,
  output logic              reg_wr_en,
  output logic [31:0]       reg_wdata,
  output logic [3:0]        reg_wbe
);

  logic win_hit, dec_cfg, dec_write, claim_ok;
  logic addr_ph, accept, in_data, done;
  logic cyc_write, wr_load;

  tgt_addr_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) dec_i (
    .ad_in(ad_in), .cbe_n(cbe_n), .idsel(idsel), .master_busy(master_busy),
    .win_hit(win_hit), .is_cfg(dec_cfg), .is_write(dec_write), .claim_ok(claim_ok)
  );

  tgt_phase_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .claim_ok(claim_ok), .addr_ph(addr_ph), .accept(accept), .in_data(in_data),
    .done(done), .devsel_n(devsel_n), .trdy_n(trdy_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_write <= 1'b0;
      reg_cfg   <= 1'b0;
      reg_addr  <= '0;
    end else if (accept) begin
      cyc_write <= dec_write;
      reg_cfg   <= dec_cfg;
      reg_addr  <= ad_in[WIN_BITS-1:2];
    end
  end

  assign wr_load = done && cyc_write;
  assign ad_oe   = in_data && !cyc_write;
  assign ad_out  = ad_oe ? reg_rdata : '0;

  tgt_wr_capture #(.LANES(4)) cap_i (
    .clk(clk), .rst_n(rst_n), .load(wr_load), .ad_in(ad_in), .cbe_n(cbe_n),
    .wdata(reg_wdata), .wbe(reg_wbe), .wr_en(reg_wr_en)
  );

endmodule

// File: rtl/tgt_cycle_decoder_chk.sv
module tgt_cycle_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_ph,
  input logic       win_hit,
  input logic       dec_cfg,
  input logic       idsel,
  input logic       master_busy,
  input logic       irdy_n,
  input logic       devsel_n,
  input logic       trdy_n,
  input logic       ad_oe,
  input logic       reg_wr_en
);

  // R5
  master_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && master_busy) |=> devsel_n);

  // R4
  cfg_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && dec_cfg && !idsel) |=> devsel_n);

  // R3
  outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && !win_hit && !dec_cfg) |=> devsel_n);

  // R6
  claim_from_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(addr_ph));

  // R9
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && !irdy_n) |=> devsel_n);

  // R9
  hold_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && irdy_n) |=> !devsel_n);

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R7
  drive_only_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !devsel_n);

  // R10
  ready_tracks_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_n == devsel_n);

endmodule

bind tgt_cycle_decoder tgt_cycle_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr_ph(addr_ph), .win_hit(win_hit),
  .dec_cfg(dec_cfg), .idsel(idsel), .master_busy(master_busy), .irdy_n(irdy_n),
  .devsel_n(devsel_n), .trdy_n(trdy_n), .ad_oe(ad_oe), .reg_wr_en(reg_wr_en)
);

// File: tb/tgt_cycle_decoder_tb_top.sv
module tgt_cycle_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, master_busy = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0, reg_rdata = '0;
  logic [31:0] ad_out, reg_wdata;
  logic        ad_oe, devsel_n, trdy_n, reg_cfg, reg_wr_en;
  logic [5:0]  reg_addr;
  logic [3:0]  reg_wbe;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tgt_cycle_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .master_busy(master_busy), .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .reg_addr(reg_addr),
    .reg_cfg(reg_cfg), .reg_rdata(reg_rdata), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_wbe(reg_wbe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {claim, busy, idsel, cmd[3:0], addr[31:0]}
  localparam int NV = 11;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 4'b0110, 32'h4000_0104},
    {1'b1, 1'b0, 1'b0, 4'b0111, 32'h4000_01FC},
    {1'b0, 1'b0, 1'b0, 4'b0110, 32'h4000_0200},
    {1'b0, 1'b0, 1'b0, 4'b0111, 32'h4000_00FC},
    {1'b0, 1'b0, 1'b0, 4'b0010, 32'h4000_0104},
    {1'b1, 1'b0, 1'b1, 4'b1010, 32'h0000_0010},
    {1'b0, 1'b0, 1'b0, 4'b1011, 32'h0000_0020},
    {1'b1, 1'b0, 1'b1, 4'b0110, 32'h4000_0108},
    {1'b0, 1'b1, 1'b0, 4'b0110, 32'h4000_0104},
    {1'b1, 1'b0, 1'b1, 4'b1011, 32'h1234_5678},
    {1'b1, 1'b0, 1'b0, 4'b0111, 32'h4000_0100}
  };

  // One transaction: address phase, optional waits, one data phase.
  task automatic xact(input logic [3:0] cmd, input logic [31:0] addr,
                      input logic sel, input logic busy, input bit exp_claim,
                      input logic [31:0] data, input logic [3:0] be_n,
                      input int waits, input bit hold_frame);
    bit wr = cmd[0];
    bit cfg = (cmd == 4'b1010) || (cmd == 4'b1011);
    frame_n = 1'b0; ad_in = addr; cbe_n = cmd; idsel = sel; master_busy = busy;
    @(posedge clk); @(negedge clk);
    chk(devsel_n == !exp_claim, "R2/R3/R4/R5 claim", 32'(devsel_n), 32'(!exp_claim));
    chk(trdy_n == devsel_n, "R10 trdy", 32'(trdy_n), 32'(devsel_n));
    idsel = 1'b0; master_busy = 1'b0;
    frame_n = hold_frame ? 1'b0 : 1'b1;
    ad_in = data; cbe_n = be_n; irdy_n = 1'b1;
    for (int w = 0; w < waits; w++) begin
      @(posedge clk); @(negedge clk);
      chk(devsel_n == !exp_claim, "R9 wait hold", 32'(devsel_n), 32'(!exp_claim));
    end
    irdy_n = 1'b0;
    #1;
    if (exp_claim) begin
      chk(reg_addr == addr[7:2], "R7 reg_addr", 32'(reg_addr), 32'(addr[7:2]));
      chk(reg_cfg == cfg, "R7 reg_cfg", 32'(reg_cfg), 32'(cfg));
      chk(ad_oe == !wr, "R7 ad_oe", 32'(ad_oe), 32'(!wr));
      if (!wr) chk(ad_out == reg_rdata, "R7 ad_out", ad_out, reg_rdata);
    end else begin
      chk(ad_oe == 1'b0, "R3 no drive", 32'(ad_oe), 32'h0);
    end
    @(posedge clk); @(negedge clk);
    chk(devsel_n == 1'b1, "R9 release", 32'(devsel_n), 32'h1);
    chk(reg_wr_en == (exp_claim && wr), "R8 strobe", 32'(reg_wr_en), 32'(exp_claim && wr));
    irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
  endtask

  initial begin
    #200000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(devsel_n && trdy_n, "R1 devsel/trdy", 32'({devsel_n, trdy_n}), 32'h3);
    chk(!ad_oe && !reg_wr_en, "R1 oe/wr_en", 32'({ad_oe, reg_wr_en}), 32'h0);
    chk(reg_wdata == 0 && reg_wbe == 0, "R1 wdata", reg_wdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      reg_rdata = 32'hC0DE_0000 + 32'(i);
      xact(VEC[i][35:32], VEC[i][31:0], VEC[i][36], VEC[i][37], VEC[i][38],
           32'h5A5A_0000 + 32'(i), 4'h0, 0, 1'b0);
      frame_n = 1'b1;
      @(negedge clk);
      chk(reg_wr_en == 1'b0, "R8 one pulse", 32'(reg_wr_en), 32'h0);
    end

    // R8 full write then partial-lane merge
    xact(4'b0111, 32'h4000_0110, 1'b0, 1'b0, 1'b1, 32'hAABB_CCDD, 4'b0000, 0, 1'b0);
    chk(reg_wdata == 32'hAABB_CCDD, "R8 full write", reg_wdata, 32'hAABB_CCDD);
    chk(reg_wbe == 4'hF, "R8 wbe full", 32'(reg_wbe), 32'hF);
    @(negedge clk);
    xact(4'b0111, 32'h4000_0114, 1'b0, 1'b0, 1'b1, 32'h1122_3344, 4'b1010, 0, 1'b0);
    chk(reg_wdata == 32'hAA22_CC44, "R8 lane merge", reg_wdata, 32'hAA22_CC44);
    chk(reg_wbe == 4'b0101, "R8 wbe partial", 32'(reg_wbe), 32'h5);
    @(negedge clk);

    // R9 wait states on a read
    reg_rdata = 32'hFEED_BEEF;
    xact(4'b0110, 32'h4000_0120, 1'b0, 1'b0, 1'b1, 32'h0, 4'h0, 3, 1'b0);
    @(negedge clk);

    // R6 frame held low through completion: no second claim
    xact(4'b0110, 32'h4000_0124, 1'b0, 1'b0, 1'b1, 32'h0, 4'h0, 0, 1'b1);
    ad_in = 32'h4000_0124; cbe_n = 4'b0110;
    @(posedge clk); @(negedge clk);
    chk(devsel_n == 1'b1, "R6 held frame", 32'(devsel_n), 32'h1);
    frame_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
    // R6 fresh frame after idle is claimed again
    xact(4'b0110, 32'h4000_0124, 1'b0, 1'b0, 1'b1, 32'h0, 4'h0, 0, 1'b0);
    @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule